// File: doc/BRIEF.md
# Privilege Mode Address Segment Checker

This block holds the processor's current privilege level (user, kernel or debug) and classifies each 32-bit virtual address against the segments that level may reach. Exception, debug-exception and return strobes drive the level. Any access is then labelled with a segment code and a mapped/unmapped indication. An address-error flag is raised when a user-level access reaches outside the low half of the address space.

A switchable debug window sits inside the top kernel segment, at 0xFF20_0000 to 0xFF3F_FFFF. When the core is at debug level and the window enable is high, addresses in that window are reported as the debug segment. In every other case they are reported as ordinary top-kernel-segment addresses. The privilege level is registered. The address classification is purely combinational on the address and the current level.

Top module: `priv_seg_guard`

## Requirements
- R1: A clock edge with `rst_n` low puts the level in kernel, reported on `mode_o` as 2'b01 (user is 2'b00, debug is 2'b10).
- R2: A clock edge with `exc_i` high and `dbg_exc_i` low puts the level in kernel, whatever the level was before.
- R3: A clock edge with `dbg_exc_i` high puts the level in debug. This takes precedence over `exc_i` and over both return strobes in the same cycle.
- R4: A clock edge with `eret_i` high at kernel level moves the level to user if `eret_user_i` is high, and keeps it at kernel otherwise. `eret_i` has no effect at user or debug level.
- R5: A clock edge with `dret_i` high at debug level moves the level to kernel. `dret_i` has no effect at user or kernel level.
- R6: `seg_o` classifies the address as follows: 0 for 0x0000_0000 to 0x7FFF_FFFF; 1 for 0x8000_0000 to 0x9FFF_FFFF; 2 for 0xA000_0000 to 0xBFFF_FFFF; 3 for 0xC000_0000 to 0xDFFF_FFFF; 4 for 0xE000_0000 to 0xFFFF_FFFF (except in the R8 case).
- R7: `unmapped_o` is high exactly when `seg_o` is 1 or 2.
- R8: At debug level with `dseg_en_i` high, an address from 0xFF20_0000 to 0xFF3F_FFFF gives `seg_o` = 5 and `in_dseg_o` high. In any other case, such an address gives `seg_o` = 4 and `in_dseg_o` low.
- R9: At user level with `acc_valid_i` high, an address of 0x8000_0000 or above raises `addr_err_o`. An address below 0x8000_0000 does not.
- R10: `addr_err_o` is low at kernel and debug level for every address, and low whenever `acc_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_i | input | 1 | Ordinary exception strobe |
| dbg_exc_i | input | 1 | Debug exception strobe |
| eret_i | input | 1 | Return-from-exception strobe |
| eret_user_i | input | 1 | Return to user level on `eret_i` |
| dret_i | input | 1 | Return-from-debug strobe |
| dseg_en_i | input | 1 | Debug window decode enable |
| acc_valid_i | input | 1 | Address qualifies an access |
| vaddr_i | input | 32 | Virtual address |
| mode_o | output | 2 | Current level: 00 user, 01 kernel, 10 debug |
| seg_o | output | 3 | Segment code (R6, R8) |
| unmapped_o | output | 1 | Segment bypasses translation |
| in_dseg_o | output | 1 | Address hits the enabled debug window |
| addr_err_o | output | 1 | Address-error exception flag |

## Verification
A strobe acts at the rising edge at which it is seen. Its effect on `mode_o` is therefore visible one edge later, and it also changes the classification of any address held on the inputs. Segment code, unmapped, window and error results are combinational and are due in the same cycle as the address. The bench changes inputs at the falling edge and samples a short delay later for the combinational results. For level changes, it samples at the falling edge that follows the rising edge consuming the strobe.

// File: rtl/priv_seg_pkg.sv
// Package: shared encodings for the privilege level and segment codes.
// Assumes: 2-bit level code and 3-bit segment code, as seen at the top ports.
package priv_seg_pkg;

    typedef enum logic [1:0] {
        LVL_USER   = 2'b00,
        LVL_KERNEL = 2'b01,
        LVL_DEBUG  = 2'b10
    } lvl_t;

    typedef enum logic [2:0] {
        SEG_LOW   = 3'd0,
        SEG_K0    = 3'd1,
        SEG_K1    = 3'd2,
        SEG_K2    = 3'd3,
        SEG_K3    = 3'd4,
        SEG_DBG   = 3'd5
    } seg_t;

endpackage

// File: rtl/psg_level_reg.sv
// Module: privilege level register.
// Holds the user/kernel/debug level. It is updated on the rising edge from reset and the strobes.
// Assumes: synchronous active-low reset; the precedence is
// reset > debug exception > exception > returns.
module psg_level_reg
    import priv_seg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_i,
    input  logic dbg_exc_i,
    input  logic eret_i,
    input  logic eret_user_i,
    input  logic dret_i,
    output lvl_t lvl_o
);

    lvl_t lvl_q;
    lvl_t lvl_d;

    // Next-level selection with fixed precedence among the strobes.
    always_comb begin
        lvl_d = lvl_q;
        if (dbg_exc_i) begin
            lvl_d = LVL_DEBUG;
        end else if (exc_i) begin
            lvl_d = LVL_KERNEL;
        end else if (dret_i && lvl_q == LVL_DEBUG) begin
            lvl_d = LVL_KERNEL;
        end else if (eret_i && lvl_q == LVL_KERNEL) begin
            lvl_d = eret_user_i ? LVL_USER : LVL_KERNEL;
        end
    end

    // Level state flop with synchronous reset to kernel.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LVL_KERNEL;
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/psg_seg_decode.sv
// Module: segment classifier.
// Maps a virtual address to a segment code and an unmapped flag. The top three address bits
// pick the segment, and the debug window overrides the top segment when it is active.
// Assumes: the window is aligned to its own power-of-two size.
module psg_seg_decode
    import priv_seg_pkg::*;
#(
    parameter int          VA_W       = 32,
    parameter logic [31:0] WIN_BASE   = 32'hFF20_0000,
    parameter int          WIN_SZ_LOG = 21
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  lvl_t            lvl_i,
    input  logic            win_en_i,
    output seg_t            seg_o,
    output logic            unmapped_o,
    output logic            in_win_o
);

    localparam int TAG_W = VA_W - WIN_SZ_LOG;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[VA_W-1:WIN_SZ_LOG];

    logic win_hit;
    seg_t base_seg;

    // Window address match, gated by level and enable.
    always_comb begin
        win_hit  = (vaddr_i[VA_W-1:WIN_SZ_LOG] == WIN_TAG);
        in_win_o = win_hit && win_en_i && (lvl_i == LVL_DEBUG);
    end

    // Coarse segment from the three top address bits.
    always_comb begin
        if (!vaddr_i[VA_W-1]) begin
            base_seg = SEG_LOW;
        end else begin
            case (vaddr_i[VA_W-2:VA_W-3])
                2'b00:   base_seg = SEG_K0;
                2'b01:   base_seg = SEG_K1;
                2'b10:   base_seg = SEG_K2;
                default: base_seg = SEG_K3;
            endcase
        end
    end

    // Final segment code and the unmapped indication.
    always_comb begin
        seg_o      = in_win_o ? SEG_DBG : base_seg;
        unmapped_o = (seg_o == SEG_K0) || (seg_o == SEG_K1);
    end

endmodule

// File: rtl/psg_fault.sv
// Module: address-error generator.
// Flags a qualified user-level access to the upper half of the address space.
// Assumes: the kernel and debug levels may reach every address.
module psg_fault
    import priv_seg_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  lvl_t            lvl_i,
    input  logic            valid_i,
    output logic            err_o
);

    // Error only for a valid user access with the top address bit set.
    always_comb begin
        err_o = valid_i && (lvl_i == LVL_USER) && vaddr_i[VA_W-1];
    end

endmodule

// File: rtl/priv_seg_guard.sv
// Module: privilege mode address segment checker (top).
// Combines the level register, the segment classifier and the address-error generator.
// Assumes: the level is registered, and the classification is combinational on the address.
module priv_seg_guard
    import priv_seg_pkg::*;
#(
    parameter int          VA_W       = 32,
    parameter logic [31:0] WIN_BASE   = 32'hFF20_0000,
    parameter int          WIN_SZ_LOG = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_i,
    input  logic            dbg_exc_i,
    input  logic            eret_i,
    input  logic            eret_user_i,
    input  logic            dret_i,
    input  logic            dseg_en_i,
    input  logic            acc_valid_i,
    input  logic [VA_W-1:0] vaddr_i,
    output logic [1:0]      mode_o,
    output logic [2:0]      seg_o,
    output logic            unmapped_o,
    output logic            in_dseg_o,
    output logic            addr_err_o
);

    lvl_t lvl;
    seg_t seg;

    psg_level_reg u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_i       (exc_i),
        .dbg_exc_i   (dbg_exc_i),
        .eret_i      (eret_i),
        .eret_user_i (eret_user_i),
        .dret_i      (dret_i),
        .lvl_o       (lvl)
    );

    psg_seg_decode #(
        .VA_W       (VA_W),
        .WIN_BASE   (WIN_BASE),
        .WIN_SZ_LOG (WIN_SZ_LOG)
    ) u_decode (
        .vaddr_i    (vaddr_i),
        .lvl_i      (lvl),
        .win_en_i   (dseg_en_i),
        .seg_o      (seg),
        .unmapped_o (unmapped_o),
        .in_win_o   (in_dseg_o)
    );

    psg_fault #(
        .VA_W (VA_W)
    ) u_fault (
        .vaddr_i (vaddr_i),
        .lvl_i   (lvl),
        .valid_i (acc_valid_i),
        .err_o   (addr_err_o)
    );

    assign mode_o = lvl;
    assign seg_o  = seg;

endmodule

// File: rtl/priv_seg_guard_chk.sv
// Module: assertion checker for priv_seg_guard, attached by bind.
// Checks the level transitions and the error/window relations at the ports.
module priv_seg_guard_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_i,
    input logic            dbg_exc_i,
    input logic            eret_i,
    input logic            eret_user_i,
    input logic            dret_i,
    input logic            dseg_en_i,
    input logic            acc_valid_i,
    input logic [VA_W-1:0] vaddr_i,
    input logic [1:0]      mode_o,
    input logic [2:0]      seg_o,
    input logic            unmapped_o,
    input logic            in_dseg_o,
    input logic            addr_err_o
);

    a_r3_dbg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc_i |=> mode_o == 2'b10);

    a_r2_exc_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && !dbg_exc_i) |=> mode_o == 2'b01);

    a_r5_dret_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && dret_i && !exc_i && !dbg_exc_i) |=> mode_o == 2'b01);

    a_r4_eret_user: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && eret_i && eret_user_i && !exc_i && !dbg_exc_i)
        |=> mode_o == 2'b00);

    a_r9_user_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && mode_o == 2'b00 && vaddr_i[VA_W-1]) |-> addr_err_o);

    a_r10_priv_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 || !acc_valid_i) |-> !addr_err_o);

    a_r8_window_level: assert property (@(posedge clk) disable iff (!rst_n)
        in_dseg_o |-> (mode_o == 2'b10 && dseg_en_i && seg_o == 3'd5));

    a_r7_unmapped_seg: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_o |-> (seg_o == 3'd1 || seg_o == 3'd2));

endmodule

bind priv_seg_guard priv_seg_guard_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/priv_seg_guard_bench.sv
// Bench for priv_seg_guard.
// A vector table is walked by one loop; directed tests then cover reset and strobe precedence.
module priv_seg_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_i, dbg_exc_i, eret_i, eret_user_i, dret_i;
    logic        dseg_en_i, acc_valid_i;
    logic [31:0] vaddr_i;
    logic [1:0]  mode_o;
    logic [2:0]  seg_o;
    logic        unmapped_o, in_dseg_o, addr_err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    priv_seg_guard u_priv_seg_guard (.*);

    localparam logic [1:0] MU = 2'b00, MK = 2'b01, MD = 2'b10;

    // Entry layout: {level, addr, win_en, valid, seg, unmapped, in_win, err}.
    localparam int NV = 16;
    localparam logic [41:0] VEC [NV] = '{
        {MU, 32'h0000_0000, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
        {MU, 32'h7FFF_FFFF, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
        {MU, 32'h8000_0000, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1},
        {MU, 32'hFF20_0000, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1},
        {MU, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0},
        {MK, 32'h8000_0000, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0},
        {MK, 32'h9FFF_FFFF, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0},
        {MK, 32'hA000_0000, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0},
        {MK, 32'hC000_0000, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
        {MK, 32'hFF20_0000, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        {MD, 32'hFF20_0000, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0},
        {MD, 32'hFF3F_FFFF, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0},
        {MD, 32'hFF40_0000, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        {MD, 32'hFF1F_FFFF, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        {MD, 32'hFF20_0000, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
        {MD, 32'hBFFF_FFFF, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one set of strobes for a single rising edge, then settle at the falling edge.
    task automatic strobe(input logic e, input logic d, input logic r, input logic ru, input logic dr);
        exc_i = e; dbg_exc_i = d; eret_i = r; eret_user_i = ru; dret_i = dr;
        @(negedge clk);
        exc_i = 0; dbg_exc_i = 0; eret_i = 0; eret_user_i = 0; dret_i = 0;
    endtask

    task automatic go_level(input logic [1:0] m);
        case (m)
            MK: strobe(1, 0, 0, 0, 0);
            MD: strobe(0, 1, 0, 0, 0);
            default: begin strobe(1, 0, 0, 0, 0); strobe(0, 0, 1, 1, 0); end
        endcase
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; exc_i = 0; dbg_exc_i = 0; eret_i = 0; eret_user_i = 0; dret_i = 0;
        dseg_en_i = 0; acc_valid_i = 0; vaddr_i = '0;
        @(negedge clk); @(negedge clk);
        check("R1 reset level", mode_o, MK);
        rst_n = 1;
        @(negedge clk);
        check("R1 level held after reset", mode_o, MK);

        // Table walk: set the level, apply the address, check the combinational results.
        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            go_level(v[41:40]);
            check("R1-level setup", mode_o, v[41:40]);
            vaddr_i = v[39:8]; dseg_en_i = v[7]; acc_valid_i = v[6];
            #2;
            check("R6 seg", seg_o, v[5:3]);
            check("R7 unmapped", unmapped_o, v[2]);
            check("R8 window", in_dseg_o, v[1]);
            check(v[41:40] == MU && v[6] ? "R9 user err" : "R10 no err", addr_err_o, v[0]);
        end

        acc_valid_i = 0; dseg_en_i = 0; vaddr_i = '0;

        // R3: the debug exception beats the ordinary exception in the same cycle.
        go_level(MK);
        strobe(1, 1, 0, 0, 0);
        check("R3 debug beats exception", mode_o, MD);
        // R4: eret is ignored at debug level.
        strobe(0, 0, 1, 1, 0);
        check("R4 eret ignored in debug", mode_o, MD);
        // R2: an exception from debug goes to kernel.
        strobe(1, 0, 0, 0, 0);
        check("R2 exception to kernel", mode_o, MK);
        // R4: eret without the user bit stays in kernel.
        strobe(0, 0, 1, 0, 0);
        check("R4 eret no user bit", mode_o, MK);
        // R5: dret is ignored at kernel level.
        strobe(0, 0, 0, 0, 1);
        check("R5 dret ignored in kernel", mode_o, MK);
        strobe(0, 0, 1, 1, 0);
        check("R4 eret to user", mode_o, MU);
        // R5: dret is ignored at user level; eret likewise.
        strobe(0, 0, 0, 0, 1);
        check("R5 dret ignored in user", mode_o, MU);
        strobe(0, 0, 1, 0, 0);
        check("R4 eret ignored in user", mode_o, MU);
        // R2: an exception from user goes to kernel.
        strobe(1, 0, 0, 0, 0);
        check("R2 user to kernel", mode_o, MK);
        // R3 then R5: enter debug, then return.
        strobe(0, 1, 0, 0, 0);
        check("R3 kernel to debug", mode_o, MD);
        strobe(0, 0, 0, 0, 1);
        check("R5 dret to kernel", mode_o, MK);
        // R3: the debug exception beats eret in the same cycle.
        strobe(0, 1, 1, 1, 0);
        check("R3 debug beats eret", mode_o, MD);
        // R9: error appears in the cycle after the level drops to user, with the address held.
        go_level(MU);
        vaddr_i = 32'hE000_0000; acc_valid_i = 1; #2;
        check("R9 user upper access", addr_err_o, 1'b1);
        strobe(1, 0, 0, 0, 0);
        #2;
        check("R10 kernel no err", addr_err_o, 1'b0);
        // R1: reset from debug level.
        strobe(0, 1, 0, 0, 0);
        rst_n = 0;
        @(negedge clk);
        check("R1 reset from debug", mode_o, MK);
        rst_n = 1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule